// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block is the data path that a host SMBus controller uses for block transfers. Software reaches it through a small byte-wide register window. It has an auxiliary control register, a status byte, a byte-count register, a block-data register, and a control register whose only effect here is that reading it rewinds the software index. The transaction sequencer reaches it through a separate port that fetches bytes to send, delivers received bytes, reports a received byte count, and reads back a stall and a "last byte" indication.

There are two modes, and the buffer-enable bit of the auxiliary register selects between them. In buffer mode a 32-entry store sits between software and the sequencer. Each side has its own index, and that index advances once per access and saturates at the top entry. In byte-by-byte mode the block-data register is a single holding byte. Every byte the sequencer moves sets a byte-done flag, and the sequencer stalls until software writes 1 to that flag. The mode is latched when a transaction starts. The bus engine and the checksum logic live elsewhere.

Top module: `smbb_top`

## Requirements
- R1: The auxiliary register (select 4) stores bit 1 as buffer enable and bit 0 as CRC enable; it reads back as {6'b0, bits}, and `crc_en` follows bit 0.
- R2: With buffer enable set, each read or write of the block-data register (select 3) accesses the store entry at the software index and then steps that index by one.
- R3: A read of the control register (select 1) returns 0 and sets the software index to entry 0.
- R4: Both indices saturate at entry 31 and never wrap to 0.
- R5: `seq_start` sets the sequencer index to 0. In buffer mode `seq_tx_data` shows the store entry at that index, and each `seq_take` or `seq_put` (a `seq_put` writes `seq_rx_data` into that entry) steps the index by one.
- R6: `seq_start` latches buffer enable into `seq_buf_mode`, and the new value is visible in the following cycle.
- R7: The count register (select 2) is written by software or by `seq_cnt_vld` with `seq_rx_data`. A received count of 0 or above 32 sets `cnt_err` (also status bit 4). `seq_start` clears that flag.
- R8: `seq_last` is high when the sequencer index plus one equals the count, which marks the byte about to move as the final one.
- R9: In byte mode the block-data register is a single holding byte shared by software writes and `seq_put`. `seq_tx_data` shows it, and any `seq_take` or `seq_put` sets byte-done (status bit 7) and raises `seq_stall`.
- R10: Writing status (select 0) with bit 7 set clears byte-done. A status write with bit 7 clear leaves byte-done unchanged.
- R11: A write to the auxiliary register that clears buffer enable while it is set resets the software index to 0.
- R12: After reset every register, the store and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software register write strobe |
| sw_re | input | 1 | Software register read strobe |
| sw_sel | input | 3 | Register select |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data, valid in the strobe cycle |
| crc_en | output | 1 | CRC enable bit toward the checksum logic |
| seq_start | input | 1 | Transaction start pulse |
| seq_take | input | 1 | Sequencer consumed `seq_tx_data` |
| seq_put | input | 1 | Sequencer delivers `seq_rx_data` |
| seq_cnt_vld | input | 1 | `seq_rx_data` carries the received count |
| seq_rx_data | input | 8 | Received byte or count |
| seq_tx_data | output | 8 | Byte to transmit next |
| seq_buf_mode | output | 1 | Latched mode: 1 buffer, 0 byte-by-byte |
| seq_stall | output | 1 | Byte mode handshake pending |
| seq_last | output | 1 | Next byte is the final one |
| cnt_err | output | 1 | Received count out of range |

## Verification
Read data is combinational, so a register read is compared in the same cycle as its strobe, half a period after the inputs change. Every side effect of an access or a sequencer pulse (index steps, mode latch, byte-done, count error) lands on the next clock edge, so it is compared in the cycle after the stimulus. The bench drives one pulse per cycle and queues each expected value together with its check. The monitor pops that entry on the falling edge of the cycle in which the check is raised.

// File: rtl/smbb_pkg.sv
package smbb_pkg;
    typedef enum logic [2:0] {
        SEL_STS = 3'd0,
        SEL_CTL = 3'd1,
        SEL_CNT = 3'd2,
        SEL_BLK = 3'd3,
        SEL_AUX = 3'd4
    } smbb_sel_e;

    localparam int AUX_CRC_BIT  = 0;
    localparam int AUX_BUF_BIT  = 1;
    localparam int STS_DONE_BIT = 7;
    localparam int STS_CERR_BIT = 4;
endpackage

// File: rtl/smbb_index.sv
module smbb_index #(
    parameter int DEPTH = 32,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] TOP = IW'(DEPTH - 1);

    typedef struct packed {
        logic [IW-1:0] idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.idx = '0;
        end else if (step && st_q.idx != TOP) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx = st_q.idx;

    // R4
    idx_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx == TOP && !clr) |=> (idx == TOP));

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && st_q.idx != TOP) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/smbb_store.sv
module smbb_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] a_idx,
    input  logic          a_we,
    input  logic [DW-1:0] a_data,
    output logic [DW-1:0] a_rdata,
    input  logic [IW-1:0] b_idx,
    input  logic          b_we,
    input  logic [DW-1:0] b_data,
    output logic [DW-1:0] b_rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] ent;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (a_we) st_d.ent[a_idx] = a_data;
        if (b_we) st_d.ent[b_idx] = b_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_rdata = st_q.ent[a_idx];
    assign b_rdata = st_q.ent[b_idx];

    // R5
    seq_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |=> (st_q.ent[$past(b_idx)] == $past(b_data)));
endmodule

// File: rtl/smbb_hsk.sv
module smbb_hsk #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ev,
    input  logic          w1c,
    input  logic          cnt_we,
    input  logic [DW-1:0] cnt_wdata,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_cnt,
    output logic          done,
    output logic [DW-1:0] cnt,
    output logic          cerr
);
    localparam logic [DW-1:0] MAXCNT = DW'(DEPTH);

    typedef struct packed {
        logic          done;
        logic [DW-1:0] cnt;
        logic          cerr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) st_d.cerr = 1'b0;
        if (cnt_we) st_d.cnt = cnt_wdata;
        if (rx_vld) begin
            st_d.cnt  = rx_cnt;
            st_d.cerr = (rx_cnt == '0) || (rx_cnt > MAXCNT);
        end
        if (w1c) st_d.done = 1'b0;
        if (ev)  st_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign cnt  = st_q.cnt;
    assign cerr = st_q.cerr;

    // R9
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> done);

    // R7
    cnt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_vld |=> (cnt == $past(rx_cnt)));
endmodule

// File: rtl/smbb_top.sv
module smbb_top
    import smbb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we,
    input  logic          sw_re,
    input  logic [2:0]    sw_sel,
    input  logic [DW-1:0] sw_wdata,
    output logic [DW-1:0] sw_rdata,
    output logic          crc_en,
    input  logic          seq_start,
    input  logic          seq_take,
    input  logic          seq_put,
    input  logic          seq_cnt_vld,
    input  logic [DW-1:0] seq_rx_data,
    output logic [DW-1:0] seq_tx_data,
    output logic          seq_buf_mode,
    output logic          seq_stall,
    output logic          seq_last,
    output logic          cnt_err
);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [1:0]    aux;
        logic          mode;
        logic [DW-1:0] hold;
    } st_t;

    st_t st_d, st_q;

    logic          sel_blk, sel_aux, sel_ctl, sel_sts, sel_cnt;
    logic          buf_en;
    logic          sw_clr, sw_step, seq_step;
    logic [IW-1:0] sw_idx, seq_idx;
    logic          mem_a_we, mem_b_we, hs_ev, hs_w1c;
    logic [DW-1:0] mem_a_rd, mem_b_rd, cnt_val;
    logic          done;

    assign sel_blk = (sw_sel == SEL_BLK);
    assign sel_aux = (sw_sel == SEL_AUX);
    assign sel_ctl = (sw_sel == SEL_CTL);
    assign sel_sts = (sw_sel == SEL_STS);
    assign sel_cnt = (sw_sel == SEL_CNT);
    assign buf_en  = st_q.aux[AUX_BUF_BIT];

    assign sw_clr   = (sw_re && sel_ctl) ||
                      (sw_we && sel_aux && buf_en && !sw_wdata[AUX_BUF_BIT]);
    assign sw_step  = buf_en && sel_blk && (sw_re || sw_we);
    assign seq_step = seq_take || seq_put;
    assign mem_a_we = sw_we && sel_blk && buf_en;
    assign mem_b_we = seq_put && st_q.mode;
    assign hs_ev    = !st_q.mode && seq_step;
    assign hs_w1c   = sw_we && sel_sts && sw_wdata[STS_DONE_BIT];

    smbb_index #(.DEPTH(DEPTH)) u_sw_idx (
        .clk(clk), .rst_n(rst_n), .clr(sw_clr), .step(sw_step), .idx(sw_idx)
    );

    smbb_index #(.DEPTH(DEPTH)) u_seq_idx (
        .clk(clk), .rst_n(rst_n), .clr(seq_start), .step(seq_step), .idx(seq_idx)
    );

    smbb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(sw_idx), .a_we(mem_a_we), .a_data(sw_wdata), .a_rdata(mem_a_rd),
        .b_idx(seq_idx), .b_we(mem_b_we), .b_data(seq_rx_data), .b_rdata(mem_b_rd)
    );

    smbb_hsk #(.DEPTH(DEPTH), .DW(DW)) u_hsk (
        .clk(clk), .rst_n(rst_n), .start(seq_start), .ev(hs_ev), .w1c(hs_w1c),
        .cnt_we(sw_we && sel_cnt), .cnt_wdata(sw_wdata),
        .rx_vld(seq_cnt_vld), .rx_cnt(seq_rx_data),
        .done(done), .cnt(cnt_val), .cerr(cnt_err)
    );

    always_comb begin
        st_d = st_q;
        if (sw_we && sel_aux) st_d.aux = sw_wdata[1:0];
        if (seq_start) st_d.mode = buf_en;
        if (sw_we && sel_blk && !buf_en) st_d.hold = sw_wdata;
        if (seq_put && !st_q.mode) st_d.hold = seq_rx_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sw_rdata = '0;
        case (sw_sel)
            SEL_STS: begin
                sw_rdata[STS_DONE_BIT] = done;
                sw_rdata[STS_CERR_BIT] = cnt_err;
            end
            SEL_CNT: sw_rdata = cnt_val;
            SEL_BLK: sw_rdata = buf_en ? mem_a_rd : st_q.hold;
            SEL_AUX: sw_rdata[1:0] = st_q.aux;
            default: sw_rdata = '0;
        endcase
    end

    assign crc_en       = st_q.aux[AUX_CRC_BIT];
    assign seq_buf_mode = st_q.mode;
    assign seq_tx_data  = st_q.mode ? mem_b_rd : st_q.hold;
    assign seq_stall    = !st_q.mode && done;
    assign seq_last     = ((DW'(seq_idx) + 1'b1) == cnt_val);

    // R6
    mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> (seq_buf_mode == $past(buf_en)));

    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_w1c && !hs_ev) |=> !seq_stall);
endmodule

// File: tb/smbb_top_tb.sv
module smbb_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    localparam int K_RD = 0, K_TX = 1, K_LAST = 2, K_STALL = 3,
                   K_CERR = 4, K_CRC = 5, K_MODE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_we = 1'b0, sw_re = 1'b0;
    logic [2:0] sw_sel = '0;
    logic [7:0] sw_wdata = '0, sw_rdata;
    logic       crc_en;
    logic       seq_start = 1'b0, seq_take = 1'b0, seq_put = 1'b0, seq_cnt_vld = 1'b0;
    logic [7:0] seq_rx_data = '0, seq_tx_data;
    logic       seq_buf_mode, seq_stall, seq_last, cnt_err;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    logic  mon_go = 1'b0;
    int    tests = 0, fails = 0;
    bit    finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbb_top u_dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_re(sw_re), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .crc_en(crc_en),
        .seq_start(seq_start), .seq_take(seq_take), .seq_put(seq_put),
        .seq_cnt_vld(seq_cnt_vld), .seq_rx_data(seq_rx_data),
        .seq_tx_data(seq_tx_data), .seq_buf_mode(seq_buf_mode),
        .seq_stall(seq_stall), .seq_last(seq_last), .cnt_err(cnt_err)
    );

    function automatic logic [7:0] actual(int kind);
        case (kind)
            K_RD:    return sw_rdata;
            K_TX:    return seq_tx_data;
            K_LAST:  return {7'b0, seq_last};
            K_STALL: return {7'b0, seq_stall};
            K_CERR:  return {7'b0, cnt_err};
            K_CRC:   return {7'b0, crc_en};
            default: return {7'b0, seq_buf_mode};
        endcase
    endfunction

    // monitor: pops the scoreboard on the falling edge
    always @(negedge clk) begin
        if (mon_go && sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = actual(it.kind);
            tests++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int kind, logic [7:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] d);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        tick();
        sw_we = 1'b0;
    endtask

    task automatic rd_chk(logic [2:0] sel, logic [7:0] exp, string tag);
        sw_re = 1'b1; sw_sel = sel;
        push(K_RD, exp, tag);
        mon_go = 1'b1;
        tick();
        sw_re = 1'b0; mon_go = 1'b0;
    endtask

    task automatic rd_only(logic [2:0] sel);
        sw_re = 1'b1; sw_sel = sel;
        tick();
        sw_re = 1'b0;
    endtask

    task automatic chk(int kind, logic [7:0] exp, string tag);
        push(kind, exp, tag);
        mon_go = 1'b1;
        tick();
        mon_go = 1'b0;
    endtask

    task automatic s_start();
        seq_start = 1'b1; tick(); seq_start = 1'b0;
    endtask
    task automatic s_take();
        seq_take = 1'b1; tick(); seq_take = 1'b0;
    endtask
    task automatic s_put(logic [7:0] d);
        seq_put = 1'b1; seq_rx_data = d; tick(); seq_put = 1'b0;
    endtask
    task automatic s_cnt(logic [7:0] d);
        seq_cnt_vld = 1'b1; seq_rx_data = d; tick(); seq_cnt_vld = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        rd_chk(3'd0, 8'h00, "R12 status after reset");
        rd_chk(3'd4, 8'h00, "R12 aux after reset");
        chk(K_STALL, 8'h00, "R12 stall after reset");
        chk(K_MODE,  8'h00, "R12 mode after reset");

        // R1 aux register
        wr(3'd4, 8'h03);
        rd_chk(3'd4, 8'h03, "R1 aux readback");
        chk(K_CRC, 8'h01, "R1 crc_en follows bit 0");

        // R2 fill buffer, R4 saturation on write
        rd_chk(3'd1, 8'h00, "R3 control reads zero");
        for (int i = 0; i < 32; i++) wr(3'd3, 8'(i * 7 + 3));
        wr(3'd3, 8'hEE);                     // lands on entry 31 (saturated)
        rd_only(3'd1);                       // R3 rewind
        for (int i = 0; i < 31; i++) rd_chk(3'd3, 8'(i * 7 + 3), "R2 buffer read sequence");
        rd_chk(3'd3, 8'hEE, "R4 entry 31 after saturated write");
        rd_chk(3'd3, 8'hEE, "R4 read index stays at 31");
        rd_only(3'd1);
        rd_chk(3'd3, 8'h03, "R3 control read rewinds to entry 0");

        // R6 mode latch, R5 transmit path
        s_start();
        chk(K_MODE, 8'h01, "R6 buffer mode latched");
        chk(K_TX, 8'h03, "R5 tx entry 0");
        s_take();
        chk(K_TX, 8'h0A, "R5 tx entry 1 after take");

        // R5 receive path
        s_start();
        s_put(8'hA0); s_put(8'hA1); s_put(8'hA2);
        rd_only(3'd1);
        rd_chk(3'd3, 8'hA0, "R5 received byte 0");
        rd_chk(3'd3, 8'hA1, "R5 received byte 1");
        rd_chk(3'd3, 8'hA2, "R5 received byte 2");

        // R7 count validation
        s_start(); s_cnt(8'd32);
        chk(K_CERR, 8'h00, "R7 count 32 accepted");
        rd_chk(3'd2, 8'd32, "R7 count register holds 32");
        s_start(); s_cnt(8'd0);
        chk(K_CERR, 8'h01, "R7 count 0 rejected");
        rd_chk(3'd0, 8'h10, "R7 status bit 4 on count error");
        s_start();
        chk(K_CERR, 8'h00, "R7 start clears count error");
        s_cnt(8'd33);
        chk(K_CERR, 8'h01, "R7 count 33 rejected");
        s_start(); s_cnt(8'd1);
        chk(K_CERR, 8'h00, "R7 count 1 accepted");

        // R8 last byte indication
        wr(3'd2, 8'd3);
        s_start();
        chk(K_LAST, 8'h00, "R8 first of three not last");
        s_take();
        chk(K_LAST, 8'h00, "R8 second of three not last");
        s_take();
        chk(K_LAST, 8'h01, "R8 third of three is last");

        // R11 clearing buffer enable resets the software index
        rd_only(3'd1);
        wr(3'd3, 8'h11); wr(3'd3, 8'h22);
        wr(3'd4, 8'h01);
        wr(3'd4, 8'h03);
        rd_chk(3'd3, 8'h11, "R11 index reset by clearing buffer enable");

        // R9 byte-by-byte write
        wr(3'd4, 8'h01);
        wr(3'd3, 8'h55);
        s_start();
        chk(K_MODE, 8'h00, "R6 byte mode latched");
        chk(K_TX, 8'h55, "R9 preloaded byte on tx");
        chk(K_STALL, 8'h00, "R9 no stall before first byte");
        s_take();
        chk(K_STALL, 8'h01, "R9 stall after byte taken");
        rd_chk(3'd0, 8'h80, "R9 byte-done in status bit 7");
        wr(3'd3, 8'h66);
        chk(K_TX, 8'h66, "R9 next byte supplied");
        wr(3'd0, 8'h00);
        chk(K_STALL, 8'h01, "R10 writing 0 leaves byte-done set");
        wr(3'd0, 8'h80);
        chk(K_STALL, 8'h00, "R10 write 1 clears byte-done");

        // R9 byte-by-byte read
        s_put(8'h9A);
        chk(K_STALL, 8'h01, "R9 stall after byte received");
        rd_chk(3'd3, 8'h9A, "R9 received byte in holding register");
        wr(3'd0, 8'h80);
        rd_chk(3'd0, 8'h00, "R10 status clear after write 1");

        finished = 1'b1;
        tick();
        summary();
        $finish;
    end
endmodule